// File: doc/BRIEF.md
# Staggered Half-Word Adder with Flags

This block performs a two-operand add over a word split into two half-words and spreads the work over three pipeline phases. In the first phase the lower half is summed and its carry is stored. In the second phase the upper half is summed with that stored carry. In the third phase the zero, sign, carry and overflow flags are formed from the complete result. One phase is one clock of a double-rate clock.

The lower half of the sum appears on its own output one phase after issue. A consumer can therefore begin work on it before the upper half exists, for example by using it as a cache index. Either operand can be taken from the result of the most recently issued operation in place of the port value. Each half-word of that result feeds the half of the same significance as soon as that half is ready. A chain of dependent adds can therefore issue on every phase, with no bubbles.

Top module: `halfstep_adder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lo_vld` and `res_vld` are low, and `res`, `lo_sum` and `flags` are zero.
- R2: An operation issued with `issue_vld` high in cycle N drives `lo_vld` high in cycle N+1, with `lo_sum` equal to the lower half of its sum.
- R3: The same operation drives `res_vld` high in cycle N+3, with the full sum on `res`, and the lower half of `res` equal to the `lo_sum` shown two cycles earlier.
- R4: The result equals (A + B) modulo 2^WIDTH, with the carry out of the lower half added into the upper half.
- R5: With `byp_a` (or `byp_b`) high, operand A (or B) is the result of the most recently issued operation instead of `opa` (or `opb`); each half is taken from the half of the same significance.
- R6: Operations may issue on every cycle, including dependent chains that bypass on every issue, and every result is delivered with no bubble.
- R7: `flags` bit 3 is zero (result is all zeros), bit 2 is sign (result MSB), bit 1 is carry (unsigned carry out of the full add), bit 0 is overflow (two's-complement overflow).
- R8: Cycles without an issue do not change the bypass source, so a bypass after a gap still uses the last issued operation's result.
- R9: A cycle with `issue_vld` low produces no `lo_vld` one cycle later and no `res_vld` three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (double rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An operation is issued this cycle |
| opa | input | WIDTH | Operand A from the register side |
| opb | input | WIDTH | Operand B from the register side |
| byp_a | input | 1 | Take operand A from the previous result |
| byp_b | input | 1 | Take operand B from the previous result |
| lo_vld | output | 1 | Early lower half is valid |
| lo_sum | output | WIDTH/2 | Lower half of the sum, one cycle after issue |
| res_vld | output | 1 | Full result and flags are valid |
| res | output | WIDTH | Full sum |
| flags | output | 4 | {zero, sign, carry, overflow} |

## Verification
On every cycle the assertions check the valid timing of both outputs, the absence of valids after idle cycles, and the agreement between the early lower half and the later full result. They also check that the sign and zero flags match the result, and that a double bypass yields twice the previous lower half. Only the bench scenarios show the arithmetic itself: carries crossing the half boundary, the carry and overflow flags, random dependent chains checked against a full-width reference sum, and bypasses that reach back across idle gaps.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;
   typedef struct packed {
      logic zero;
      logic sign;
      logic carry;
      logic ovf;
   } hs_flags_t;

   localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/halfstep_opsel.sv
module halfstep_opsel #(
   parameter int unsigned W = 16
) (
   input  logic         sel_byp,
   input  logic [W-1:0] reg_val,
   input  logic [W-1:0] byp_val,
   output logic [W-1:0] opnd
);
   assign opnd = sel_byp ? byp_val : reg_val;
endmodule

// File: rtl/halfstep_slice.sv
module halfstep_slice #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] wide;
   assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = wide[W-1:0];
   assign cout = wide[W];
endmodule

// File: rtl/halfstep_flags.sv
module halfstep_flags
   import halfstep_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] sum,
   input  logic             cout,
   input  logic             a_msb,
   input  logic             b_msb,
   output hs_flags_t        fl
);
   always_comb begin
      fl.zero  = (sum == '0);
      fl.sign  = sum[WIDTH-1];
      fl.carry = cout;
      fl.ovf   = (a_msb == b_msb) && (sum[WIDTH-1] != a_msb);
   end
endmodule

// File: rtl/halfstep_adder.sv
module halfstep_adder
   import halfstep_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_vld,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             byp_a,
   input  logic             byp_b,
   output logic             lo_vld,
   output logic [WIDTH/2-1:0] lo_sum,
   output logic             res_vld,
   output logic [WIDTH-1:0] res,
   output logic [3:0]       flags
);
   localparam int unsigned HALF = WIDTH / 2;

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("halfstep_adder: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [NUM_OPND-1:0][WIDTH-1:0] opnd_in;
   logic [NUM_OPND-1:0]            byp_in;
   assign opnd_in[0] = opa;
   assign opnd_in[1] = opb;
   assign byp_in     = {byp_b, byp_a};

   // phase 1 state
   logic                           v1_q;
   logic [HALF-1:0]                lo_q;
   logic                           cy_q;
   logic [NUM_OPND-1:0][HALF-1:0]  hi_opnd_q;
   logic [NUM_OPND-1:0]            hi_byp_q;
   // phase 2 state
   logic                           v2_q;
   logic [HALF-1:0]                hi_q;
   logic [HALF-1:0]                lo2_q;
   logic                           cout_q;
   logic [NUM_OPND-1:0]            msb_q;
   // phase 3 state
   logic                           v3_q;
   logic [WIDTH-1:0]               res_q;
   hs_flags_t                      flags_q;

   logic [NUM_OPND-1:0][HALF-1:0]  lo_eff;
   logic [NUM_OPND-1:0][HALF-1:0]  hi_eff;
   logic [NUM_OPND-1:0]            msb_eff;

   genvar k;
   generate
      for (k = 0; k < NUM_OPND; k++) begin : g_opnd
         halfstep_opsel #(.W(HALF)) u_sel_lo (
            .sel_byp (byp_in[k]),
            .reg_val (opnd_in[k][HALF-1:0]),
            .byp_val (lo_q),
            .opnd    (lo_eff[k])
         );
         halfstep_opsel #(.W(HALF)) u_sel_hi (
            .sel_byp (hi_byp_q[k]),
            .reg_val (hi_opnd_q[k]),
            .byp_val (hi_q),
            .opnd    (hi_eff[k])
         );
         assign msb_eff[k] = hi_eff[k][HALF-1];
      end
   endgenerate

   logic [HALF-1:0] lo_d, hi_d;
   logic            lo_cy, hi_cy;

   halfstep_slice #(.W(HALF)) u_lo_slice (
      .a    (lo_eff[0]),
      .b    (lo_eff[1]),
      .cin  (1'b0),
      .sum  (lo_d),
      .cout (lo_cy)
   );

   halfstep_slice #(.W(HALF)) u_hi_slice (
      .a    (hi_eff[0]),
      .b    (hi_eff[1]),
      .cin  (cy_q),
      .sum  (hi_d),
      .cout (hi_cy)
   );

   hs_flags_t flags_d;
   halfstep_flags #(.WIDTH(WIDTH)) u_flags (
      .sum   ({hi_q, lo2_q}),
      .cout  (cout_q),
      .a_msb (msb_q[0]),
      .b_msb (msb_q[1]),
      .fl    (flags_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q      <= 1'b0;
         lo_q      <= '0;
         cy_q      <= 1'b0;
         hi_opnd_q <= '0;
         hi_byp_q  <= '0;
         v2_q      <= 1'b0;
         hi_q      <= '0;
         lo2_q     <= '0;
         cout_q    <= 1'b0;
         msb_q     <= '0;
         v3_q      <= 1'b0;
         res_q     <= '0;
         flags_q   <= '0;
      end else begin
         v1_q <= issue_vld;
         v2_q <= v1_q;
         v3_q <= v2_q;
         if (issue_vld) begin
            lo_q     <= lo_d;
            cy_q     <= lo_cy;
            hi_byp_q <= byp_in;
            for (int i = 0; i < NUM_OPND; i++) begin
               hi_opnd_q[i] <= opnd_in[i][WIDTH-1:HALF];
            end
         end
         if (v1_q) begin
            hi_q   <= hi_d;
            lo2_q  <= lo_q;
            cout_q <= hi_cy;
            msb_q  <= msb_eff;
         end
         if (v2_q) begin
            res_q   <= {hi_q, lo2_q};
            flags_q <= flags_d;
         end
      end
   end

   assign lo_vld  = v1_q;
   assign lo_sum  = lo_q;
   assign res_vld = v3_q;
   assign res     = res_q;
   assign flags   = flags_q;
endmodule

// File: rtl/halfstep_adder_chk.sv
module halfstep_adder_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               issue_vld,
   input logic               byp_a,
   input logic               byp_b,
   input logic               lo_vld,
   input logic [WIDTH/2-1:0] lo_sum,
   input logic               res_vld,
   input logic [WIDTH-1:0]   res,
   input logic [3:0]         flags
);
   localparam int unsigned HALF = WIDTH / 2;

   AST_LO_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld |=> lo_vld); // R2
   AST_NO_LO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |=> !lo_vld); // R9
   AST_RES_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      lo_vld |=> ##1 res_vld); // R3
   AST_RES_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(lo_vld, 2)); // R9
   AST_LO_MATCHES_RES: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (res[HALF-1:0] == $past(lo_sum, 2))); // R3
   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (flags[2] == res[WIDTH-1])); // R7
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (flags[3] == (res == '0))); // R7
   AST_DOUBLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && byp_a && byp_b) |=> (lo_sum == {$past(lo_sum[HALF-2:0]), 1'b0})); // R5
endmodule

bind halfstep_adder halfstep_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_vld (issue_vld),
   .byp_a     (byp_a),
   .byp_b     (byp_b),
   .lo_vld    (lo_vld),
   .lo_sum    (lo_sum),
   .res_vld   (res_vld),
   .res       (res),
   .flags     (flags)
);

// File: tb/halfstep_adder_tb.sv
module halfstep_adder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        byp_a = 1'b0, byp_b = 1'b0;
   logic        lo_vld, res_vld;
   logic [15:0] lo_sum;
   logic [31:0] res;
   logic [3:0]  flags;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   halfstep_adder u_dut (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld),
      .opa(opa), .opb(opb), .byp_a(byp_a), .byp_b(byp_b),
      .lo_vld(lo_vld), .lo_sum(lo_sum), .res_vld(res_vld),
      .res(res), .flags(flags)
   );

   // slot tables filled by each scenario
   logic        s_iss [64];
   logic [31:0] s_a   [64];
   logic [31:0] s_b   [64];
   logic        s_ba  [64];
   logic        s_bb  [64];
   logic [31:0] e_sum [64];
   logic [3:0]  e_fl  [64];
   logic [31:0] ref_last = '0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_slots();
      for (int i = 0; i < 64; i++) begin
         s_iss[i] = 1'b0; s_a[i] = '0; s_b[i] = '0; s_ba[i] = 1'b0; s_bb[i] = 1'b0;
      end
   endtask

   // drive slots 0..n-1, one per cycle; check lo one cycle and res three cycles later
   task automatic run_slots(input int n, input string req);
      for (int s = 0; s < n + 3; s++) begin
         @(negedge clk);
         if (s >= 1) begin
            if (s - 1 < n && s_iss[s-1]) begin
               chk(req, "lo_vld", {31'b0, lo_vld}, 32'd1);
               chk(req, "lo_sum", {16'b0, lo_sum}, {16'b0, e_sum[s-1][15:0]});
            end else begin
               chk("R9", "lo_vld idle", {31'b0, lo_vld}, 32'd0);
            end
         end
         if (s >= 3) begin
            if (s_iss[s-3]) begin
               chk(req, "res_vld", {31'b0, res_vld}, 32'd1);
               chk(req, "res", res, e_sum[s-3]);
               chk("R7", "flags", {28'b0, flags}, {28'b0, e_fl[s-3]});
            end else begin
               chk("R9", "res_vld idle", {31'b0, res_vld}, 32'd0);
            end
         end
         if (s < n && s_iss[s]) begin
            logic [31:0] a, b;
            logic [32:0] w;
            issue_vld = 1'b1; opa = s_a[s]; opb = s_b[s];
            byp_a = s_ba[s]; byp_b = s_bb[s];
            a = s_ba[s] ? ref_last : s_a[s];
            b = s_bb[s] ? ref_last : s_b[s];
            w = {1'b0, a} + {1'b0, b};
            e_sum[s] = w[31:0];
            e_fl[s]  = {w[31:0] == 32'd0, w[31], w[32],
                        (a[31] == b[31]) && (w[31] != a[31])};
            ref_last = w[31:0];
         end else begin
            issue_vld = 1'b0; opa = $urandom; opb = $urandom;
            byp_a = $urandom; byp_b = $urandom;
         end
      end
      issue_vld = 1'b0; byp_a = 1'b0; byp_b = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "lo_vld in reset", {31'b0, lo_vld}, 32'd0);
      chk("R1", "res_vld in reset", {31'b0, res_vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "res after reset", res, 32'd0);
      chk("R1", "lo_sum after reset", {16'b0, lo_sum}, 32'd0);
      chk("R1", "flags after reset", {28'b0, flags}, 32'd0);
      chk("R1", "res_vld after reset", {31'b0, res_vld}, 32'd0);
   endtask

   // R4 R7: carries across the half boundary, zero, overflow
   task automatic t_corners();
      clear_slots();
      s_iss[0] = 1; s_a[0] = 32'h0000_FFFF; s_b[0] = 32'h0000_0001;
      s_iss[1] = 1; s_a[1] = 32'hFFFF_FFFF; s_b[1] = 32'h0000_0001;
      s_iss[2] = 1; s_a[2] = 32'h7FFF_FFFF; s_b[2] = 32'h0000_0001;
      s_iss[3] = 1; s_a[3] = 32'h8000_0000; s_b[3] = 32'h8000_0000;
      s_iss[4] = 1; s_a[4] = 32'h1234_8000; s_b[4] = 32'h0000_8000;
      s_iss[5] = 1; s_a[5] = 32'h0000_0000; s_b[5] = 32'h0000_0000;
      run_slots(6, "R4");
   endtask

   // R5 R6: back-to-back dependent chain with random bypass selects
   task automatic t_chain();
      clear_slots();
      for (int i = 0; i < 48; i++) begin
         s_iss[i] = 1; s_a[i] = $urandom; s_b[i] = $urandom;
         s_ba[i] = (i > 0) && ($urandom_range(0, 3) != 0);
         s_bb[i] = (i > 0) && ($urandom_range(0, 2) == 0);
      end
      s_ba[1] = 1; s_bb[1] = 1;
      run_slots(48, "R6");
   endtask

   // R8 R9: idle gaps, bypass reaches back to the last issued op
   task automatic t_gaps();
      clear_slots();
      for (int i = 0; i < 30; i++) begin
         s_iss[i] = (i % 3 != 1) && (i % 7 != 5);
         s_a[i] = $urandom; s_b[i] = $urandom;
         s_ba[i] = (i > 0) && $urandom_range(0, 1);
         s_bb[i] = (i > 0) && ($urandom_range(0, 3) == 0);
      end
      s_iss[8] = 0; s_iss[9] = 0; s_iss[10] = 1; s_ba[10] = 1; s_bb[10] = 1;
      run_slots(30, "R8");
   endtask

   // R5: one-sided bypass of each operand with carry into the upper half
   task automatic t_byp_sides();
      clear_slots();
      s_iss[0] = 1; s_a[0] = 32'h0001_FFF0; s_b[0] = 32'h0000_0020;
      s_iss[1] = 1; s_a[1] = 32'hDEAD_BEEF; s_b[1] = 32'h0000_FFFF; s_ba[1] = 1;
      s_iss[2] = 1; s_a[2] = 32'h0000_0001; s_b[2] = 32'hFFFF_0000; s_bb[2] = 1;
      s_iss[4] = 1; s_a[4] = 32'h8000_0000; s_b[4] = 32'hAAAA_AAAA; s_ba[4] = 1;
      run_slots(5, "R5");
   endtask

   initial begin
      t_reset();
      t_corners();
      t_byp_sides();
      t_chain();
      t_gaps();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule